// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits on the host side of a byte-wide asynchronous flash bus and turns one request into the full bus conversation that the flash needs. A request carries an opcode, a target address and a data byte, and it is taken over a valid/ready handshake. The block then issues the unlock and command write cycles. Each write cycle has a minimum write-enable low time, a minimum write-enable high time and an address/data setup time. These minimums are given in nanoseconds and rounded up to whole clock cycles.

After the last command write, the block reads the target address again and again. It stops when bit 7 of the returned byte shows that the embedded operation has finished, or when a programmable number of poll reads has been used up. One cycle of `done` or `err` reports the outcome. Only one request is active at a time. Requests presented while the block is busy are not taken.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `fl_cs_n`, `fl_we_n` and `fl_oe_n` are all 1, and `done` and `err` are both 0.
- R2: When `req_op[1]` is 0 (opcode 00 or 01), the request programs one byte. The block issues four writes, as (data, address): (AAh, 5555h), (55h, 2AAAh), (A0h, 5555h), then (`req_data`, `req_addr`). The upper address bits are zero on the unlock writes.
- R3: Opcode 10 is a sector erase. The block issues six writes: (AAh, 5555h), (55h, 2AAAh), (80h, 5555h), (AAh, 5555h), (55h, 2AAAh), then (30h, `req_addr`).
- R4: Opcode 11 is a chip erase. It issues the same first five writes as R3. The sixth write is (10h, 5555h).
- R5: During every write pulse, `fl_we_n` stays low for exactly ceil(WE_LOW_NS/CLK_NS) cycles. `fl_cs_n` is low, and `fl_addr` and `fl_dout` do not change, for as long as `fl_we_n` is low.
- R6: Between two write pulses, `fl_we_n` stays high for at least ceil(WE_HIGH_NS/CLK_NS) cycles. `fl_addr` and `fl_dout` already hold their values in the cycle before `fl_we_n` falls.
- R7: `fl_we_n` and `fl_oe_n` are never low together. Before each poll read, `fl_oe_n` is high for at least ceil(OE_GAP_NS/CLK_NS) cycles.
- R8: After the last write, the block reads `req_addr` repeatedly. It finishes with `done` on the first read whose bit 7 equals the expected value. The expected value is `req_data[7]` for a program and 1 for either erase.
- R9: If POLL_MAX reads all miss, the block raises `err` instead of `done` and performs no further reads.
- R10: `done` and `err` are each high for a single cycle, and never together. `req_ready` goes low in the cycle after a request is taken. It stays low until the cycle in which `done` or `err` is high, and is 1 in that cycle.
- R11: Request inputs that change or stay valid while the block is busy do not change the writes or reads in progress, and they do not start a second operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; a request is taken when this and `req_valid` are both high |
| req_op | input | 2 | 00/01 program, 10 sector erase, 11 chip erase |
| req_addr | input | ADDR_W | Target byte or sector address |
| req_data | input | 8 | Byte to program |
| done | output | 1 | One-cycle pulse: operation completed |
| err | output | 1 | One-cycle pulse: poll budget used up |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_dout | output | 8 | Flash write data |
| fl_din | input | 8 | Flash read data |
| fl_cs_n | output | 1 | Flash chip select, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |

## Verification
`req_ready` falls one cycle after the accepting edge. The bench checks this at the first falling clock edge after that edge. Every strobe output is a register loaded from the next timing state, so a bus monitor that samples on each falling edge counts each low and high phase in whole cycles and compares the counts with the rounded-up minimums. The read byte is captured on the last output-enable-low cycle. The bench's flash model advances its read count only after `fl_oe_n` rises, so the number of poll reads is fixed by how many busy replies the model gives. `done` or `err` is registered together with the return to idle, so the bench checks that pulse, and `req_ready` beside it, in the same sampled cycle, then checks one cycle later that the pulse has gone.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  // timing-engine phases
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_WLOW, ST_WHIGH, ST_RGAP, ST_RLOW, ST_RHIGH
  } strobe_e;

  // sequencer phases
  typedef enum logic [2:0] {
    TS_IDLE, TS_ISSUE, TS_WAIT, TS_PISSUE, TS_PWAIT
  } seq_e;

  localparam logic [15:0] UNLOCK_ADR_A = 16'h5555;
  localparam logic [15:0] UNLOCK_ADR_B = 16'h2AAA;
  localparam logic [7:0]  UNLOCK_DAT_A = 8'hAA;
  localparam logic [7:0]  UNLOCK_DAT_B = 8'h55;
  localparam logic [7:0]  CMD_PROGRAM  = 8'hA0;
  localparam logic [7:0]  CMD_ERASE_PRE = 8'h80;
  localparam logic [7:0]  CMD_SECTOR   = 8'h30;
  localparam logic [7:0]  CMD_CHIP     = 8'h10;

  // nanoseconds to whole cycles, rounded up, never below one
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/fseq_cmd_table.sv
module fseq_cmd_table
  import fseq_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic [1:0]        op_i,
  input  logic [2:0]        step_i,
  input  logic [ADDR_W-1:0] tgt_addr_i,
  input  logic [7:0]        tgt_data_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              last_o
);

  localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(UNLOCK_ADR_A);
  localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(UNLOCK_ADR_B);

  logic is_erase;
  assign is_erase = op_i[1];

  always_comb begin
    wr_addr_o = ADR_A;
    wr_data_o = UNLOCK_DAT_A;
    last_o    = 1'b0;
    case (step_i)
      3'd0: begin
        wr_addr_o = ADR_A;
        wr_data_o = UNLOCK_DAT_A;
      end
      3'd1: begin
        wr_addr_o = ADR_B;
        wr_data_o = UNLOCK_DAT_B;
      end
      3'd2: begin
        wr_addr_o = ADR_A;
        wr_data_o = is_erase ? CMD_ERASE_PRE : CMD_PROGRAM;
      end
      3'd3: begin
        if (!is_erase) begin
          wr_addr_o = tgt_addr_i;
          wr_data_o = tgt_data_i;
          last_o    = 1'b1;
        end
      end
      3'd4: begin
        wr_addr_o = ADR_B;
        wr_data_o = UNLOCK_DAT_B;
      end
      3'd5: begin
        last_o = 1'b1;
        if (op_i[0]) begin
          wr_addr_o = ADR_A;
          wr_data_o = CMD_CHIP;
        end else begin
          wr_addr_o = tgt_addr_i;
          wr_data_o = CMD_SECTOR;
        end
      end
      default: last_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/fseq_strobe.sv
module fseq_strobe
  import fseq_pkg::*;
#(
  parameter int SETUP_CYC   = 1,
  parameter int WE_LOW_CYC  = 5,
  parameter int WE_HIGH_CYC = 2,
  parameter int OE_GAP_CYC  = 1,
  parameter int RD_CYC      = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       read_i,
  input  logic [7:0] din_i,
  output logic       fin_o,
  output logic [7:0] rd_byte_o,
  output logic       cs_n_o,
  output logic       we_n_o,
  output logic       oe_n_o
);

  localparam int M1    = (SETUP_CYC > WE_LOW_CYC) ? SETUP_CYC : WE_LOW_CYC;
  localparam int M2    = (WE_HIGH_CYC > OE_GAP_CYC) ? WE_HIGH_CYC : OE_GAP_CYC;
  localparam int M3    = (M1 > M2) ? M1 : M2;
  localparam int MAXC  = (M3 > RD_CYC) ? M3 : RD_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  strobe_e            st_q, st_nx;
  logic [CNT_W-1:0]   cnt_q, cnt_nx;
  logic               cs_n_q, we_n_q, oe_n_q;
  logic [7:0]         rd_q;
  logic               cap_en;

  function automatic logic [CNT_W-1:0] len_m1(input strobe_e s);
    case (s)
      ST_SETUP: return CNT_W'(SETUP_CYC - 1);
      ST_WLOW:  return CNT_W'(WE_LOW_CYC - 1);
      ST_WHIGH: return CNT_W'(WE_HIGH_CYC - 1);
      ST_RGAP:  return CNT_W'(OE_GAP_CYC - 1);
      ST_RLOW:  return CNT_W'(RD_CYC - 1);
      ST_RHIGH: return CNT_W'(WE_HIGH_CYC - 1);
      default:  return '0;
    endcase
  endfunction

  always_comb begin
    st_nx  = st_q;
    cnt_nx = cnt_q;
    if (st_q == ST_IDLE) begin
      if (start_i) begin
        st_nx  = read_i ? ST_RGAP : ST_SETUP;
        cnt_nx = len_m1(st_nx);
      end
    end else if (cnt_q == '0) begin
      case (st_q)
        ST_SETUP: st_nx = ST_WLOW;
        ST_WLOW:  st_nx = ST_WHIGH;
        ST_RGAP:  st_nx = ST_RLOW;
        ST_RLOW:  st_nx = ST_RHIGH;
        default:  st_nx = ST_IDLE;
      endcase
      cnt_nx = len_m1(st_nx);
    end else begin
      cnt_nx = cnt_q - 1'b1;
    end
  end

  assign fin_o  = ((st_q == ST_WHIGH) || (st_q == ST_RHIGH)) && (cnt_q == '0);
  assign cap_en = (st_q == ST_RLOW) && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      cs_n_q <= 1'b1;
      we_n_q <= 1'b1;
      oe_n_q <= 1'b1;
    end else begin
      st_q   <= st_nx;
      cnt_q  <= cnt_nx;
      cs_n_q <= (st_nx == ST_IDLE);
      we_n_q <= (st_nx != ST_WLOW);
      oe_n_q <= (st_nx != ST_RLOW);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q <= '0;
    else if (cap_en) rd_q <= din_i;
  end

  assign rd_byte_o = rd_q;
  assign cs_n_o    = cs_n_q;
  assign we_n_o    = we_n_q;
  assign oe_n_o    = oe_n_q;

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n_q && !oe_n_q));

  // R5
  we_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_q |-> !cs_n_q);

  // R7
  oe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n_q |-> !cs_n_q);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fseq_pkg::*;
#(
  parameter int ADDR_W     = 21,
  parameter int CLK_NS     = 10,
  parameter int SETUP_NS   = 10,
  parameter int WE_LOW_NS  = 50,
  parameter int WE_HIGH_NS = 20,
  parameter int OE_GAP_NS  = 10,
  parameter int RD_NS      = 150,
  parameter int POLL_MAX   = 1048576
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  output logic              done,
  output logic              err,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_dout,
  input  logic [7:0]        fl_din,
  output logic              fl_cs_n,
  output logic              fl_oe_n,
  output logic              fl_we_n
);

  localparam int SETUP_CYC   = ns_to_cyc(SETUP_NS, CLK_NS);
  localparam int WE_LOW_CYC  = ns_to_cyc(WE_LOW_NS, CLK_NS);
  localparam int WE_HIGH_CYC = ns_to_cyc(WE_HIGH_NS, CLK_NS);
  localparam int OE_GAP_CYC  = ns_to_cyc(OE_GAP_NS, CLK_NS);
  localparam int RD_CYC      = ns_to_cyc(RD_NS, CLK_NS);
  localparam int POLL_W      = $clog2(POLL_MAX + 1);
  localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_MAX - 1);

  seq_e               st_q, st_nx;
  logic [1:0]         op_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [7:0]         data_q;
  logic [2:0]         step_q, step_nx;
  logic [POLL_W-1:0]  poll_q, poll_nx;
  logic               done_q, done_nx, err_q, err_nx;
  logic [ADDR_W-1:0]  bus_addr_q, bus_addr_nx;
  logic [7:0]         bus_dout_q, bus_dout_nx;
  logic               load_req;
  logic               stb_start, stb_read, stb_fin;
  logic [7:0]         stb_byte;
  logic [ADDR_W-1:0]  tbl_addr;
  logic [7:0]         tbl_data;
  logic               tbl_last;
  logic               exp_bit7;

  fseq_cmd_table #(.ADDR_W(ADDR_W)) u_table (
    .op_i       (op_q),
    .step_i     (step_q),
    .tgt_addr_i (addr_q),
    .tgt_data_i (data_q),
    .wr_addr_o  (tbl_addr),
    .wr_data_o  (tbl_data),
    .last_o     (tbl_last)
  );

  fseq_strobe #(
    .SETUP_CYC   (SETUP_CYC),
    .WE_LOW_CYC  (WE_LOW_CYC),
    .WE_HIGH_CYC (WE_HIGH_CYC),
    .OE_GAP_CYC  (OE_GAP_CYC),
    .RD_CYC      (RD_CYC)
  ) u_strobe (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (stb_start),
    .read_i    (stb_read),
    .din_i     (fl_din),
    .fin_o     (stb_fin),
    .rd_byte_o (stb_byte),
    .cs_n_o    (fl_cs_n),
    .we_n_o    (fl_we_n),
    .oe_n_o    (fl_oe_n)
  );

  // erase completes when the array reads back as ones
  assign exp_bit7 = op_q[1] ? 1'b1 : data_q[7];

  always_comb begin
    st_nx       = st_q;
    step_nx     = step_q;
    poll_nx     = poll_q;
    done_nx     = 1'b0;
    err_nx      = 1'b0;
    load_req    = 1'b0;
    bus_addr_nx = bus_addr_q;
    bus_dout_nx = bus_dout_q;
    stb_start   = 1'b0;
    stb_read    = 1'b0;
    case (st_q)
      TS_IDLE: begin
        if (req_valid) begin
          load_req = 1'b1;
          step_nx  = '0;
          poll_nx  = '0;
          st_nx    = TS_ISSUE;
        end
      end
      TS_ISSUE: begin
        stb_start   = 1'b1;
        bus_addr_nx = tbl_addr;
        bus_dout_nx = tbl_data;
        st_nx       = TS_WAIT;
      end
      TS_WAIT: begin
        if (stb_fin) begin
          if (tbl_last) begin
            st_nx = TS_PISSUE;
          end else begin
            step_nx = step_q + 3'd1;
            st_nx   = TS_ISSUE;
          end
        end
      end
      TS_PISSUE: begin
        stb_start   = 1'b1;
        stb_read    = 1'b1;
        bus_addr_nx = addr_q;
        st_nx       = TS_PWAIT;
      end
      TS_PWAIT: begin
        if (stb_fin) begin
          if (stb_byte[7] == exp_bit7) begin
            done_nx = 1'b1;
            st_nx   = TS_IDLE;
          end else if (poll_q == POLL_LAST) begin
            err_nx = 1'b1;
            st_nx  = TS_IDLE;
          end else begin
            poll_nx = poll_q + 1'b1;
            st_nx   = TS_PISSUE;
          end
        end
      end
      default: st_nx = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= TS_IDLE;
      step_q     <= '0;
      poll_q     <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      bus_addr_q <= '0;
      bus_dout_q <= '0;
    end else begin
      st_q       <= st_nx;
      step_q     <= step_nx;
      poll_q     <= poll_nx;
      done_q     <= done_nx;
      err_q      <= err_nx;
      bus_addr_q <= bus_addr_nx;
      bus_dout_q <= bus_dout_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (load_req) begin
      op_q   <= req_op;
      addr_q <= req_addr;
      data_q <= req_data;
    end
  end

  assign req_ready = (st_q == TS_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign fl_addr   = bus_addr_q;
  assign fl_dout   = bus_dout_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  // R10
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  // R10
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R5
  we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dout)));

  // R6
  we_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_we_n) |-> ($stable(fl_addr) && $stable(fl_dout)));

  // R8
  poll_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> (fl_addr == addr_q));

endmodule

// File: tb/flash_cmd_seq_tb.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb;

  localparam int AW       = 21;
  localparam int CLK_NS   = 10;
  localparam int WLOW_NS  = 45;
  localparam int WHIGH_NS = 20;
  localparam int GAP_NS   = 10;
  localparam int RD_NS    = 40;
  localparam int PMAX     = 4;
  localparam int WE_LOW   = (WLOW_NS + CLK_NS - 1) / CLK_NS;
  localparam int WE_HIGH  = (WHIGH_NS + CLK_NS - 1) / CLK_NS;
  localparam int OE_GAP   = (GAP_NS + CLK_NS - 1) / CLK_NS;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [1:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [7:0]    req_data;
  logic          done, err;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_dout;
  logic [7:0]    fl_din;
  logic          fl_cs_n, fl_oe_n, fl_we_n;

  always #5 clk = ~clk;

  flash_cmd_seq #(
    .ADDR_W(AW), .CLK_NS(CLK_NS), .SETUP_NS(10), .WE_LOW_NS(WLOW_NS),
    .WE_HIGH_NS(WHIGH_NS), .OE_GAP_NS(GAP_NS), .RD_NS(RD_NS), .POLL_MAX(PMAX)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .done(done), .err(err), .fl_addr(fl_addr), .fl_dout(fl_dout),
    .fl_din(fl_din), .fl_cs_n(fl_cs_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
  );

  int n_chk = 0;
  int n_bad = 0;

  // flash model and bus monitor state
  logic [1:0]    m_op;
  logic [7:0]    m_data;
  logic [AW-1:0] m_addr;
  int            m_busy;
  logic [AW-1:0] wa [0:7];
  logic [7:0]    wd [0:7];
  int            wlen [0:7];
  int            wgap [0:7];
  bit            wsetup [0:7];
  int            wr_n, rd_n, lo_run, hi_run, oe_hi, rgap_min;
  int            hold_bad, rd_addr_bad, both_low, ready_bad;
  logic [AW-1:0] hold_a, prev_addr;
  logic [7:0]    hold_d, prev_dout;
  logic          prev_we, prev_oe;
  bit            mon_active;

  always_comb begin
    if (rd_n < m_busy)
      fl_din = m_op[1] ? 8'h00 : {~m_data[7], m_data[6:0]};
    else
      fl_din = m_op[1] ? 8'hFF : m_data;
  end

  always @(negedge clk) begin
    if (!fl_we_n) begin
      if (prev_we) begin
        if (wr_n < 8) begin
          wgap[wr_n]   = hi_run;
          wsetup[wr_n] = (fl_addr == prev_addr) && (fl_dout == prev_dout);
        end
        lo_run = 1;
        hold_a = fl_addr;
        hold_d = fl_dout;
      end else begin
        lo_run++;
        if (fl_addr != hold_a || fl_dout != hold_d) hold_bad++;
      end
      hi_run = 0;
    end else begin
      if (!prev_we) begin
        if (wr_n < 8) begin
          wa[wr_n]   = hold_a;
          wd[wr_n]   = hold_d;
          wlen[wr_n] = lo_run;
        end
        wr_n++;
      end
      hi_run++;
    end
    if (!fl_oe_n) begin
      if (prev_oe) begin
        if (oe_hi < rgap_min) rgap_min = oe_hi;
        if (fl_addr != m_addr) rd_addr_bad++;
      end
      oe_hi = 0;
    end else begin
      if (!prev_oe) rd_n++;
      oe_hi++;
    end
    if (!fl_we_n && !fl_oe_n) both_low++;
    if (mon_active && req_ready && !done && !err) ready_bad++;
    prev_we   = fl_we_n;
    prev_oe   = fl_oe_n;
    prev_addr = fl_addr;
    prev_dout = fl_dout;
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic exp_step(input logic [1:0] op, input int k, input logic [AW-1:0] a,
                          input logic [7:0] d, output logic [AW-1:0] ea, output logic [7:0] ed);
    ea = AW'(21'h5555);
    ed = 8'hAA;
    case (k)
      1, 4: begin ea = AW'(21'h2AAA); ed = 8'h55; end
      2: ed = op[1] ? 8'h80 : 8'hA0;
      3: if (!op[1]) begin ea = a; ed = d; end
      5: if (op[0]) ed = 8'h10; else begin ea = a; ed = 8'h30; end
      default: ;
    endcase
  endtask

  task automatic run_txn(input logic [1:0] op, input logic [AW-1:0] a,
                         input logic [7:0] d, input int busy, input bit hold);
    int nexp, nrd;
    bit exp_done, got_done, got_err, got_rdy, seen;
    logic [AW-1:0] ea;
    logic [7:0] ed;
    string tseq;
    tseq = (op == 2'b10) ? "R3" : (op == 2'b11) ? "R4" : "R2";
    m_op = op; m_data = d; m_addr = a; m_busy = busy;
    wr_n = 0; rd_n = 0; rgap_min = 1000; hold_bad = 0; rd_addr_bad = 0;
    both_low = 0; ready_bad = 0; seen = 0;
    chk(req_ready == 1'b1, "R10 ready idle before request", req_ready, 1);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    tick();
    chk(req_ready == 1'b0, "R10 ready low after accept", req_ready, 0);
    mon_active = 1'b1;
    if (hold) begin
      req_op = ~op; req_addr = ~a; req_data = ~d;   // R11 stimulus while busy
    end else begin
      req_valid = 1'b0;
    end
    for (int i = 0; i < 5000; i++) begin
      if (done || err) begin seen = 1; break; end
      tick();
    end
    mon_active = 1'b0;
    req_valid  = 1'b0;
    got_done = done; got_err = err; got_rdy = req_ready;
    chk(seen, "R8 completion reported", seen, 1);
    tick();
    chk(!done && !err, "R10 single-cycle pulse", {done, err}, 0);
    chk(fl_cs_n == 1'b1, "R11 no second operation", fl_cs_n, 1);
    tick();
    chk(fl_cs_n == 1'b1 && req_ready, "R11 stays idle", {fl_cs_n, req_ready}, 3);

    nexp = op[1] ? 6 : 4;
    chk(wr_n == nexp, {tseq, " write count"}, wr_n, nexp);
    for (int k = 0; k < nexp && k < 8; k++) begin
      exp_step(op, k, a, d, ea, ed);
      chk(wa[k] == ea, {tseq, " write address"}, wa[k], ea);
      chk(wd[k] == ed, {tseq, " write data"}, wd[k], ed);
      chk(wlen[k] == WE_LOW, "R5 we low width", wlen[k], WE_LOW);
      chk(wsetup[k], "R6 address/data setup", wsetup[k], 1);
      if (k > 0) chk(wgap[k] >= WE_HIGH, "R6 we high gap", wgap[k], WE_HIGH);
    end
    chk(hold_bad == 0, "R5 address/data hold", hold_bad, 0);
    chk(both_low == 0, "R7 we/oe overlap", both_low, 0);
    chk(rgap_min >= OE_GAP, "R7 oe high before read", rgap_min, OE_GAP);
    exp_done = (busy < PMAX);
    nrd = exp_done ? busy + 1 : PMAX;
    chk(rd_n == nrd, exp_done ? "R8 poll read count" : "R9 poll read count", rd_n, nrd);
    chk(rd_addr_bad == 0, "R8 poll address", rd_addr_bad, 0);
    chk(got_done == exp_done, exp_done ? "R8 done" : "R9 no done", got_done, exp_done);
    chk(got_err == !exp_done, exp_done ? "R8 no err" : "R9 err", got_err, !exp_done);
    chk(got_rdy, "R10 ready with completion", got_rdy, 1);
    chk(ready_bad == 0, "R10 ready low while busy", ready_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R8: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_data = '0;
    m_op = '0; m_data = '0; m_addr = '0; m_busy = 0;
    wr_n = 0; rd_n = 0; lo_run = 0; hi_run = 0; oe_hi = 1000; rgap_min = 1000;
    hold_bad = 0; rd_addr_bad = 0; both_low = 0; ready_bad = 0; mon_active = 1'b0;
    hold_a = '0; hold_d = '0; prev_addr = '0; prev_dout = '0;
    prev_we = 1'b1; prev_oe = 1'b1;
    tick();
    tick();
    // R1 reset state, during and after reset
    chk(req_ready && fl_cs_n && fl_we_n && fl_oe_n && !done && !err,
        "R1 reset state", {req_ready, fl_cs_n, fl_we_n, fl_oe_n, done, err}, 6'b111100);
    rst_n = 1'b1;
    tick();
    tick();
    chk(req_ready && fl_cs_n && fl_we_n && fl_oe_n && !done && !err,
        "R1 idle after reset", {req_ready, fl_cs_n, fl_we_n, fl_oe_n, done, err}, 6'b111100);
    for (int op = 0; op < 4; op++) begin
      for (int b = 0; b < 6; b++) begin
        run_txn(2'(op), AW'(21'h1A0000 + op * 21'h1357 + b * 21'h0F01),
                8'(8'h35 + op * 8'h40 + b * 8'h51), b, (b == 2));
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule